// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects up to 32 interrupt sources into one request line toward a processor. Each source has a sticky pending bit and an enable bit. The block reports which enabled source wins and which handler address the processor should jump to. Software reaches every register through a small single-cycle bus port: an address, write data and a write strobe, with read data returned combinationally.

After reset the controller is in a software test mode. In this mode pending bits are set only by bus writes, so the priority and vector logic can be exercised without any device attached. Setting a one-shot control bit hands the pending bits over to the real input lines. Only a reset can undo that switch.

Each source either points the processor at a shared default handler address, or at its own programmed address taken from a per-source table. The highest input, 31, is meant to carry the request of a chained downstream controller. It is therefore the lowest-priority source.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_req`, `irq_id` and `irq_vec` are 0. Every readable register reads 0, including the control word at 0x1C, the raw status at 0x00 and the enable word at 0x08.
- R2: The control word at 0x1C has bit 0 as the output enable. While it is 0, `irq_req` stays 0 even when an enabled source is pending.
- R3: Bit 1 of the control word is the hardware-input switch, and it can only be set. A later write of 0 to that bit leaves it at 1, so the control word reads back with bit 1 still set.
- R4: While the switch is 0, a write to 0x00 ORs its one bits into the pending bits, and `irq_in` has no effect on them.
- R5: Once the switch is 1, writes to 0x00 change nothing. Each source line in `irq_in` is level-sampled on every clock and ORed into its pending bit.
- R6: A write to 0x0C clears exactly the pending bits written as one. An input line that is high in the same cycle keeps its bit set.
- R7: A pending source whose enable bit is 0 is still shown at 0x00, but it neither shows at 0x04 (status AND enable) nor raises `irq_req`. Setting its enable bit afterwards raises the request.
- R8: Source 0 has the highest priority. `irq_id` names the lowest-numbered source that is both pending and enabled.
- R9: The mode word at 0x20 holds one bit per source. A 0 makes `irq_vec` equal 0x10, and a 1 makes it the source's table entry at 0x100 + 4*id, which reads back as written.
- R10: `irq_req`, `irq_id` and `irq_vec` are registered. They follow a change of pending or enable state on the next clock edge after the state itself changes.
- R11: The acknowledge address 0x0C always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_in | input | 32 | Level-sensitive source lines |
| irq_req | output | 1 | Request to the processor |
| irq_id | output | 5 | Winning source number |
| irq_vec | output | 32 | Handler address of the winning source |

## Verification
The priority and vector path is exercised by a table of pending, enable and mode patterns:
- a lone top-priority source;
- the lowest-priority source alone in fast mode;
- several pending sources where the lowest pending one is masked;
- pending and enabled sets that do not overlap;
- a masked source below an enabled one.

Together these separate a picker that favours the wrong end, one that ignores the enable mask, and a vector mux that ignores the mode bit. Directed sequences then cover three further behaviours: the one-way mode switch, an acknowledge racing a held input, and the one-cycle output latency.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   // Register byte offsets
   localparam int unsigned OFS_STATUS  = 'h00;
   localparam int unsigned OFS_PENDING = 'h04;
   localparam int unsigned OFS_ENABLE  = 'h08;
   localparam int unsigned OFS_ACK     = 'h0C;
   localparam int unsigned OFS_CTL     = 'h1C;
   localparam int unsigned OFS_MODE    = 'h20;

   // Control word bit positions
   localparam int unsigned CTL_OUT_EN_BIT = 0;
   localparam int unsigned CTL_HW_EN_BIT  = 1;

   typedef struct packed {
      logic hw_en;
      logic out_en;
   } ctl_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hw_en,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               sw_set_we,
   input  logic [NUM_SRC-1:0] sw_set,
   input  logic               ack_we,
   input  logic [NUM_SRC-1:0] ack_mask,
   input  logic [NUM_SRC-1:0] en,
   output logic [NUM_SRC-1:0] pend,
   output logic [NUM_SRC-1:0] act
);
   logic [NUM_SRC-1:0] pend_nxt;

   // Clear first, then set: a held input survives an acknowledge
   always_comb begin
      pend_nxt = pend;
      if (ack_we)
         pend_nxt = pend_nxt & ~ack_mask;
      if (hw_en)
         pend_nxt = pend_nxt | irq_in;
      else if (sw_set_we)
         pend_nxt = pend_nxt | sw_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend_nxt;
   end

   assign act = pend & en;

   AST_SIM_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_en && !sw_set_we) |=> ((pend & ~$past(pend)) == '0)); // R4

   AST_HW_LEVEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      hw_en |=> ((pend & $past(irq_in)) == $past(irq_in))); // R5

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && !hw_en) |=> ((pend & $past(ack_mask)) == '0)); // R6
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned NUM_SRC = 32,
   localparam int unsigned IDW    = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] act,
   output logic               found,
   output logic [IDW-1:0]     id
);
   // Scan downward so the lowest index is the last one written
   always_comb begin
      found = 1'b0;
      id    = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (act[i]) begin
            found = 1'b1;
            id    = IDW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
   parameter int unsigned   NUM_SRC = 32,
   parameter int unsigned   DATA_W  = 32,
   parameter logic [31:0]   DEF_VEC = 32'h10,
   localparam int unsigned  IDW     = $clog2(NUM_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDW-1:0]    wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDW-1:0]    rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic [IDW-1:0]    sel_idx,
   input  logic              sel_fast,
   output logic [DATA_W-1:0] sel_vec
);
   logic [DATA_W-1:0] tbl [NUM_SRC];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SRC; i++) tbl[i] <= '0;
      end else if (wr_en) begin
         tbl[wr_idx] <= wr_data;
      end
   end

   assign rd_data = tbl[rd_idx];
   assign sel_vec = sel_fast ? tbl[sel_idx] : DATA_W'(DEF_VEC);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
   parameter int unsigned NUM_SRC  = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned VEC_BASE = 'h100,
   parameter logic [31:0] DEF_VEC  = 32'h10,
   localparam int unsigned IDW     = $clog2(NUM_SRC),
   localparam int unsigned VEC_END = VEC_BASE + 4 * NUM_SRC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_SRC-1:0] irq_in,
   output logic              irq_req,
   output logic [IDW-1:0]    irq_id,
   output logic [DATA_W-1:0] irq_vec
);
   import irq_vec_pkg::*;

   // Elaboration-time parameter checks
   if (NUM_SRC < 2 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("NUM_SRC must lie in 2..DATA_W");
   end
   if (VEC_BASE <= OFS_MODE || (VEC_BASE % 4) != 0) begin : g_bad_base
      $error("VEC_BASE must be word aligned above the control registers");
   end
   if (VEC_END > (1 << ADDR_W)) begin : g_bad_span
      $error("vector table does not fit the address space");
   end

   ctl_t               ctl;
   logic [NUM_SRC-1:0] en_q, mode_q, pend, act_w;
   logic               hit_status, hit_enable, hit_ack, hit_ctl, hit_mode, hit_vec;
   logic [IDW-1:0]     vec_idx, pick_id;
   logic               pick_found;
   logic [DATA_W-1:0]  tbl_rd, sel_vec;

   // Address decode
   always_comb begin
      hit_status = (bus_addr == ADDR_W'(OFS_STATUS));
      hit_enable = (bus_addr == ADDR_W'(OFS_ENABLE));
      hit_ack    = (bus_addr == ADDR_W'(OFS_ACK));
      hit_ctl    = (bus_addr == ADDR_W'(OFS_CTL));
      hit_mode   = (bus_addr == ADDR_W'(OFS_MODE));
      hit_vec    = (32'(bus_addr) >= VEC_BASE) && (32'(bus_addr) < VEC_END)
                   && (bus_addr[1:0] == 2'b00);
      vec_idx    = IDW'((32'(bus_addr) - VEC_BASE) >> 2);
   end

   // Control, enable and mode registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl    <= '0;
         en_q   <= '0;
         mode_q <= '0;
      end else if (bus_we) begin
         if (hit_ctl) begin
            ctl.out_en <= bus_wdata[CTL_OUT_EN_BIT];
            ctl.hw_en  <= ctl.hw_en | bus_wdata[CTL_HW_EN_BIT];
         end
         if (hit_enable) en_q   <= bus_wdata[NUM_SRC-1:0];
         if (hit_mode)   mode_q <= bus_wdata[NUM_SRC-1:0];
      end
   end

   irq_pend_bank #(.NUM_SRC(NUM_SRC)) i_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_en     (ctl.hw_en),
      .irq_in    (irq_in),
      .sw_set_we (bus_we && hit_status),
      .sw_set    (bus_wdata[NUM_SRC-1:0]),
      .ack_we    (bus_we && hit_ack),
      .ack_mask  (bus_wdata[NUM_SRC-1:0]),
      .en        (en_q),
      .pend      (pend),
      .act       (act_w)
   );

   irq_prio_pick #(.NUM_SRC(NUM_SRC)) i_pick (
      .act   (act_w),
      .found (pick_found),
      .id    (pick_id)
   );

   irq_vec_table #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W),
      .DEF_VEC (DEF_VEC)
   ) i_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_we && hit_vec),
      .wr_idx   (vec_idx),
      .wr_data  (bus_wdata),
      .rd_idx   (vec_idx),
      .rd_data  (tbl_rd),
      .sel_idx  (pick_id),
      .sel_fast (mode_q[pick_id]),
      .sel_vec  (sel_vec)
   );

   // Registered processor-side outputs
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_req <= 1'b0;
         irq_id  <= '0;
         irq_vec <= '0;
      end else begin
         irq_req <= ctl.out_en && pick_found;
         irq_id  <= pick_id;
         irq_vec <= pick_found ? sel_vec : '0;
      end
   end

   // Read mux
   always_comb begin
      bus_rdata = '0;
      if (hit_status)                              bus_rdata = DATA_W'(pend);
      else if (bus_addr == ADDR_W'(OFS_PENDING))   bus_rdata = DATA_W'(act_w);
      else if (hit_enable)                         bus_rdata = DATA_W'(en_q);
      else if (hit_ctl)                            bus_rdata = DATA_W'(ctl);
      else if (hit_mode)                           bus_rdata = DATA_W'(mode_q);
      else if (hit_vec)                            bus_rdata = tbl_rd;
   end

   AST_REQ_NEEDS_OUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> $past(ctl.out_en)); // R2

   AST_HW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl.hw_en) |-> ctl.hw_en); // R3

   AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (((($past(act_w) >> irq_id) & NUM_SRC'(1)) != '0)
                   && (($past(act_w) & ((NUM_SRC'(1) << irq_id) - NUM_SRC'(1))) == '0))); // R8

   AST_VEC_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && ((($past(mode_q) >> irq_id) & NUM_SRC'(1)) == '0))
      |-> (irq_vec == DATA_W'(DEF_VEC))); // R9
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] irq_in = '0;
   logic        irq_req;
   logic [4:0]  irq_id;
   logic [31:0] irq_vec;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   irq_vector_ctrl i_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_in(irq_in),
      .irq_req(irq_req), .irq_id(irq_id), .irq_vec(irq_vec)
   );

   // Row: set[101:70] enable[69:38] mode[37:6] exp_req[5] exp_id[4:0]
   localparam logic [101:0] TBL [6] = '{
      {32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 5'd0},
      {32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 1'b1, 5'd31},
      {32'h0000_00F0, 32'h0000_0060, 32'h0000_0020, 1'b1, 5'd5},
      {32'h0000_0F00, 32'h0000_00FF, 32'h0000_0000, 1'b0, 5'd0},
      {32'h0001_0100, 32'h0001_0000, 32'h0001_0000, 1'b1, 5'd16},
      {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 5'd0}
   };

   function automatic logic [31:0] prog_vec(int i);
      return 32'h4000_0000 | (32'(i) << 4);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 req", 32'(irq_req), 0);
      check("R1 id", 32'(irq_id), 0);
      check("R1 vec", irq_vec, 0);
      rd(12'h1C, d); check("R1 ctl", d, 0);
      rd(12'h00, d); check("R1 status", d, 0);
      rd(12'h08, d); check("R1 enable", d, 0);

      for (int i = 0; i < 32; i++) wr(12'h100 + 12'(4 * i), prog_vec(i));
      rd(12'h114, d); check("R9 table readback", d, prog_vec(5));

      wr(12'h1C, 32'h1);
      foreach (TBL[r]) begin
         logic [31:0] m;
         wr(12'h0C, 32'hFFFF_FFFF);
         wr(12'h08, TBL[r][69:38]);
         wr(12'h20, TBL[r][37:6]);
         wr(12'h00, TBL[r][101:70]);
         settle();
         m = TBL[r][37:6];
         check("R8 table req", 32'(irq_req), 32'(TBL[r][5]));
         if (TBL[r][5]) begin
            check("R8 table id", 32'(irq_id), 32'(TBL[r][4:0]));
            check("R9 table vec", irq_vec,
                  m[TBL[r][4:0]] ? prog_vec(int'(TBL[r][4:0])) : 32'h10);
         end
      end

      // R2 output enable gates the request
      wr(12'h0C, 32'hFFFF_FFFF);
      wr(12'h20, 32'h0);
      wr(12'h1C, 32'h0);
      wr(12'h08, 32'h4);
      wr(12'h00, 32'h4);
      settle();
      check("R2 gated", 32'(irq_req), 0);
      wr(12'h1C, 32'h1);
      settle();
      check("R2 released", 32'(irq_req), 1);

      // R7 disabled source held
      wr(12'h0C, 32'hFFFF_FFFF);
      wr(12'h08, 32'h0);
      wr(12'h00, 32'h200);
      settle();
      check("R7 no req", 32'(irq_req), 0);
      rd(12'h00, d); check("R7 status", d, 32'h200);
      rd(12'h04, d); check("R7 pending view", d, 32'h0);
      wr(12'h08, 32'h200);
      settle();
      check("R7 req later", 32'(irq_req), 1);
      check("R7 id", 32'(irq_id), 9);
      rd(12'h04, d); check("R7 pending view on", d, 32'h200);

      // R6 acknowledge, R11 ack reads 0
      wr(12'h0C, 32'hFFFF_FFFF);
      wr(12'h00, 32'h18);
      wr(12'h0C, 32'h8);
      rd(12'h00, d); check("R6 partial ack", d, 32'h10);
      rd(12'h0C, d); check("R11 ack reads 0", d, 0);

      // R4 inputs ignored in test mode
      wr(12'h0C, 32'hFFFF_FFFF);
      irq_in = 32'hFF;
      repeat (3) @(negedge clk);
      rd(12'h00, d); check("R4 input ignored", d, 0);
      irq_in = '0;

      // R3 switch is one-way
      wr(12'h1C, 32'h3);
      wr(12'h1C, 32'h1);
      rd(12'h1C, d); check("R3 sticky", d, 32'h3);

      // R5 status writes ignored, levels captured
      wr(12'h00, 32'h1);
      rd(12'h00, d); check("R5 write ignored", d, 0);
      wr(12'h08, 32'hFFFF_FFFF);
      @(negedge clk);
      irq_in = 32'h200;
      @(negedge clk);
      rd(12'h00, d); check("R5 captured", d, 32'h200);
      check("R10 not yet", 32'(irq_req), 0);
      @(negedge clk);
      check("R10 one edge later", 32'(irq_req), 1);
      check("R10 id", 32'(irq_id), 9);

      // R6 ack against held input
      wr(12'h0C, 32'h200);
      rd(12'h00, d); check("R6 input wins", d, 32'h200);
      irq_in = '0;
      wr(12'h0C, 32'h200);
      rd(12'h00, d); check("R6 cleared", d, 0);
      settle();
      check("R10 req drops", 32'(irq_req), 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule